// File: doc/BRIEF.md
# Core Board System Control Register Block

This block gives software on a processor core board one small window of word-wide control registers on a simple read/write bus. A request is one cycle with `bus_sel` high, `bus_wr` choosing the direction and a byte address whose bits above bit 1 pick the word. Read data is combinational during the read cycle. Side effects of a write show up on the next clock edge.

The window holds:
- fixed identity and status words;
- two oscillator words, which accept writes only while an unlock key is held in the lock register;
- a control word that drives a one-cycle reset request pulse and a memory remap select;
- an SDRAM configuration word whose size code is fixed at build time from `MEM_MB`;
- two flag words, each with separate set and clear addresses;
- a 32-bit reference counter advancing at `REF_HZ` from a fractional divider of the system clock;
- a one-bit software interrupt with separate IRQ and FIQ enable masks;
- a read-only memory-module descriptor table.

Accesses to words that are not decoded read as zero, change nothing, and raise a one-cycle error pulse.

Top module: `cm_sysctl`

## Requirements
- R1: Word 0 reads 0x411A3001, word 4 reads 0x00100000 and word 1 reads 0. Writes to these words change nothing.
- R2: After reset, the words read as follows: word 2 reads 0x01000048, word 7 reads 0x0007FEFF, and word 9 reads 0x00000112. Word 8 reads 0x00011122 ORed with the size code: 0x10 if MEM_MB>=256, 0x0C if >=128, 0x08 if >=64, 0x04 if >=32, else 0. Words 8 and 9 take written data as is.
- R3: A write to word 5 keeps only the low 16 bits. A read of word 5 returns the kept value, with bit 16 set while the kept value equals 0xA05F.
- R4: Writes to words 2 and 7 take effect only while word 5 holds 0xA05F; otherwise the word keeps its value.
- R5: In word 3, only bit 0 and bit 2 are kept, and bit 3 always reads 0. Writing bit 3 as 1 makes `rst_req` high for exactly the following cycle. `remap_ram` equals the kept bit 2; when it is 0, boot flash is at address 0.
- R6: Word 12 reads the flags, a write to word 12 ORs the data in, and a write to word 13 clears the bits that are 1. Words 14 and 15 do the same for a second, independent flag word.
- R7: Word 10 reads 0 right after reset. Over any window of SYS_CLK_HZ/gcd cycles it advances by exactly REF_HZ/gcd; at the defaults, 24 per 250 cycles and 12 per 125.
- R8: Bit 0 of word 20 and word 21 sets and clears the software interrupt level. Words 20, 17 and 25 all read that level in bit 0.
- R9: Words 18/19 set and clear IRQ enable bits, and words 26/27 set and clear FIQ enable bits. Words 18 and 26 read the enables back. Word 16 reads level AND IRQ enable bit 0, and word 24 reads level AND FIQ enable bit 0. `irq_out` and `fiq_out` follow the same terms.
- R10: Byte offsets 0x100–0x17F read table byte (offset−0x100)/4 in bits 7:0. Table byte 0 is 0x80, byte 3 is 0x0B, and byte 31 is the size byte (64/32/16/4/2 for the same MEM_MB ranges as R2). Offsets 0x180–0x1FF read 0.
- R11: Any access to a word outside the decoded set reads 0, changes nothing, and makes `bus_err` high for the following cycle. Words 32–35 read 0, ignore writes and do not raise `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read cycle |
| bus_err | output | 1 | Pulse one cycle after an access to an undecoded word |
| rst_req | output | 1 | One-cycle system reset request |
| remap_ram | output | 1 | 1 = RAM at address 0, 0 = boot flash at address 0 |
| irq_out | output | 1 | Interrupt request line |
| fiq_out | output | 1 | Fast interrupt request line |

## Verification
A wrong lock state shows up on the first read of the oscillator words after a write, because a protected value that changed, or one that failed to change, is visible at once. A divider accumulator that is off by one step gives a wrong tick count over a 125- or 250-cycle window, so the error appears within that window. A bad interrupt level or enable bit shows on `irq_out` or `fiq_out` at the first sampling after the write that should have changed it. A wrong decode shows as a nonzero read or a missing or spurious `bus_err` one cycle after the access.

// File: rtl/cmctl_pkg.sv
package cmctl_pkg;

    localparam int DATA_W = 32;
    localparam int KEY_W  = 16;
    localparam int SPD_IDX_W = 5;

    localparam logic [DATA_W-1:0] ID_VALUE    = 32'h411A_3001;
    localparam logic [DATA_W-1:0] STAT_VALUE  = 32'h0010_0000;
    localparam logic [DATA_W-1:0] OSC_RESET   = 32'h0100_0048;
    localparam logic [DATA_W-1:0] AUX_RESET   = 32'h0007_FEFF;
    localparam logic [DATA_W-1:0] INIT_RESET  = 32'h0000_0112;
    localparam logic [DATA_W-1:0] SDRAM_BASE  = 32'h0001_1122;
    localparam logic [KEY_W-1:0]  UNLOCK_KEY  = 16'hA05F;

    // word indices whose position software depends on
    localparam int WI_ID = 0, WI_PROC = 1, WI_OSC = 2, WI_CTRL = 3, WI_STAT = 4;
    localparam int WI_LOCK = 5, WI_AUX = 7, WI_SDRAM = 8, WI_INIT = 9, WI_REF = 10;
    localparam int WI_FLG_S = 12, WI_FLG_C = 13, WI_NVF_S = 14, WI_NVF_C = 15;
    localparam int WI_IRQ_ST = 16, WI_IRQ_RAW = 17, WI_IEN_S = 18, WI_IEN_C = 19;
    localparam int WI_SW_S = 20, WI_SW_C = 21;
    localparam int WI_FIQ_ST = 24, WI_FIQ_RAW = 25, WI_FEN_S = 26, WI_FEN_C = 27;
    localparam int WI_VOLT_LO = 32, WI_VOLT_HI = 35;
    localparam int WI_SPD_LO = 64, WI_SPD_HI = 95, WI_SPDZ_LO = 96, WI_SPDZ_HI = 127;

    typedef enum logic [4:0] {
        RID_ID, RID_PROC, RID_OSC, RID_CTRL, RID_STAT, RID_LOCK, RID_AUX,
        RID_SDRAM, RID_INIT, RID_REF, RID_FLG_S, RID_FLG_C, RID_NVF_S,
        RID_NVF_C, RID_IRQ_ST, RID_IRQ_RAW, RID_IEN_S, RID_IEN_C, RID_SW_S,
        RID_SW_C, RID_FIQ_ST, RID_FIQ_RAW, RID_FEN_S, RID_FEN_C, RID_VOLT,
        RID_SPD, RID_SPDZ, RID_NONE
    } reg_id_t;

    typedef struct packed {
        logic lvl_set;
        logic lvl_clr;
        logic ien_set;
        logic ien_clr;
        logic fen_set;
        logic fen_clr;
    } irq_cmd_t;

    function automatic reg_id_t decode_word(input int unsigned w);
        reg_id_t r;
        case (w)
            WI_ID:      r = RID_ID;
            WI_PROC:    r = RID_PROC;
            WI_OSC:     r = RID_OSC;
            WI_CTRL:    r = RID_CTRL;
            WI_STAT:    r = RID_STAT;
            WI_LOCK:    r = RID_LOCK;
            WI_AUX:     r = RID_AUX;
            WI_SDRAM:   r = RID_SDRAM;
            WI_INIT:    r = RID_INIT;
            WI_REF:     r = RID_REF;
            WI_FLG_S:   r = RID_FLG_S;
            WI_FLG_C:   r = RID_FLG_C;
            WI_NVF_S:   r = RID_NVF_S;
            WI_NVF_C:   r = RID_NVF_C;
            WI_IRQ_ST:  r = RID_IRQ_ST;
            WI_IRQ_RAW: r = RID_IRQ_RAW;
            WI_IEN_S:   r = RID_IEN_S;
            WI_IEN_C:   r = RID_IEN_C;
            WI_SW_S:    r = RID_SW_S;
            WI_SW_C:    r = RID_SW_C;
            WI_FIQ_ST:  r = RID_FIQ_ST;
            WI_FIQ_RAW: r = RID_FIQ_RAW;
            WI_FEN_S:   r = RID_FEN_S;
            WI_FEN_C:   r = RID_FEN_C;
            default: begin
                if (w >= WI_VOLT_LO && w <= WI_VOLT_HI)      r = RID_VOLT;
                else if (w >= WI_SPD_LO && w <= WI_SPD_HI)   r = RID_SPD;
                else if (w >= WI_SPDZ_LO && w <= WI_SPDZ_HI) r = RID_SPDZ;
                else                                         r = RID_NONE;
            end
        endcase
        return r;
    endfunction

    function automatic logic [7:0] sdram_size_code(input int mb);
        if (mb >= 256)      return 8'h10;
        else if (mb >= 128) return 8'h0C;
        else if (mb >= 64)  return 8'h08;
        else if (mb >= 32)  return 8'h04;
        else                return 8'h00;
    endfunction

    function automatic logic [7:0] spd_size_byte(input int mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

    function automatic logic [7:0] spd_byte(input logic [SPD_IDX_W-1:0] idx, input int mb);
        logic [7:0] b;
        case (idx)
            5'd0:  b = 8'h80;  5'd1:  b = 8'h08;  5'd2:  b = 8'h04;  5'd3:  b = 8'h0B;
            5'd4:  b = 8'h09;  5'd5:  b = 8'h01;  5'd6:  b = 8'h40;  5'd7:  b = 8'h00;
            5'd8:  b = 8'h02;  5'd9:  b = 8'hA0;  5'd10: b = 8'hA0;  5'd11: b = 8'h00;
            5'd12: b = 8'h00;  5'd13: b = 8'h08;  5'd14: b = 8'h00;  5'd15: b = 8'h01;
            5'd16: b = 8'h0E;  5'd17: b = 8'h04;  5'd18: b = 8'h1C;  5'd19: b = 8'h01;
            5'd20: b = 8'h02;  5'd21: b = 8'h20;  5'd22: b = 8'hC0;  5'd27: b = 8'h30;
            5'd28: b = 8'h28;  5'd29: b = 8'h30;  5'd30: b = 8'h28;
            5'd31: b = spd_size_byte(mb);
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cmctl_refclk.sv
module cmctl_refclk
    import cmctl_pkg::*;
#(
    parameter int SYS_CLK_HZ = 250_000_000,
    parameter int REF_HZ     = 24_000_000
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] ref_count
);
    localparam int ACC_W = $clog2(SYS_CLK_HZ + REF_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(REF_HZ);
    localparam logic [ACC_W-1:0] WRAP = ACC_W'(SYS_CLK_HZ);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic             tick;

    // fractional divider: one tick each time the phase passes SYS_CLK_HZ
    always_comb begin
        acc_sum = acc_q + STEP;
        tick    = (acc_sum >= WRAP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            ref_count <= '0;
        end else begin
            acc_q <= tick ? (acc_sum - WRAP) : acc_sum;
            if (tick) ref_count <= ref_count + 1'b1;
        end
    end
endmodule

// File: rtl/cmctl_spd.sv
module cmctl_spd
    import cmctl_pkg::*;
#(
    parameter int MEM_MB = 128
) (
    input  logic [SPD_IDX_W-1:0] idx,
    output logic [7:0]           data
);
    always_comb data = spd_byte(idx, MEM_MB);
endmodule

// File: rtl/cmctl_softint.sv
module cmctl_softint
    import cmctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  irq_cmd_t          cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic              level,
    output logic [DATA_W-1:0] irq_en,
    output logic [DATA_W-1:0] fiq_en,
    output logic              irq_out,
    output logic              fiq_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level  <= 1'b0;
            irq_en <= '0;
            fiq_en <= '0;
        end else begin
            if (cmd.lvl_set && wdata[0]) level <= 1'b1;
            if (cmd.lvl_clr && wdata[0]) level <= 1'b0;
            if (cmd.ien_set) irq_en <= irq_en | wdata;
            if (cmd.ien_clr) irq_en <= irq_en & ~wdata;
            if (cmd.fen_set) fiq_en <= fiq_en | wdata;
            if (cmd.fen_clr) fiq_en <= fiq_en & ~wdata;
        end
    end

    always_comb begin
        irq_out = level & irq_en[0];
        fiq_out = level & fiq_en[0];
    end
endmodule

// File: rtl/cm_sysctl.sv
module cm_sysctl
    import cmctl_pkg::*;
#(
    parameter int MEM_MB     = 128,
    parameter int SYS_CLK_HZ = 250_000_000,
    parameter int REF_HZ     = 24_000_000,
    parameter int ADDR_W     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              rst_req,
    output logic              remap_ram,
    output logic              irq_out,
    output logic              fiq_out
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [DATA_W-1:0] SDRAM_RESET = SDRAM_BASE | DATA_W'(sdram_size_code(MEM_MB));

    logic [WORD_W-1:0] word;
    reg_id_t           rid;
    logic              wr_en, rd_en;

    logic [DATA_W-1:0] osc_q, aux_q, sdram_q, init_q, flags_q, nvflags_q;
    logic [KEY_W-1:0]  lock_q;
    logic              led_q;
    logic              unlocked;
    logic [DATA_W-1:0] ref_count;
    logic [7:0]        spd_data;
    irq_cmd_t          icmd;
    logic              sw_level;
    logic [DATA_W-1:0] irq_en, fiq_en;

    always_comb begin
        word     = bus_addr[ADDR_W-1:2];
        rid      = decode_word(int'(unsigned'(word)));
        wr_en    = bus_sel & bus_wr;
        rd_en    = bus_sel & ~bus_wr;
        unlocked = (lock_q == UNLOCK_KEY);
    end

    cmctl_refclk #(.SYS_CLK_HZ(SYS_CLK_HZ), .REF_HZ(REF_HZ)) u_refclk (
        .clk       (clk),
        .rst       (rst),
        .ref_count (ref_count)
    );

    cmctl_spd #(.MEM_MB(MEM_MB)) u_spd (
        .idx  (word[SPD_IDX_W-1:0]),
        .data (spd_data)
    );

    always_comb begin
        icmd         = '0;
        icmd.lvl_set = wr_en && (rid == RID_SW_S);
        icmd.lvl_clr = wr_en && (rid == RID_SW_C);
        icmd.ien_set = wr_en && (rid == RID_IEN_S);
        icmd.ien_clr = wr_en && (rid == RID_IEN_C);
        icmd.fen_set = wr_en && (rid == RID_FEN_S);
        icmd.fen_clr = wr_en && (rid == RID_FEN_C);
    end

    cmctl_softint u_softint (
        .clk     (clk),
        .rst     (rst),
        .cmd     (icmd),
        .wdata   (bus_wdata),
        .level   (sw_level),
        .irq_en  (irq_en),
        .fiq_en  (fiq_en),
        .irq_out (irq_out),
        .fiq_out (fiq_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_q     <= OSC_RESET;
            aux_q     <= AUX_RESET;
            sdram_q   <= SDRAM_RESET;
            init_q    <= INIT_RESET;
            flags_q   <= '0;
            nvflags_q <= '0;
            lock_q    <= '0;
            led_q     <= 1'b0;
            remap_ram <= 1'b0;
            rst_req   <= 1'b0;
            bus_err   <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            bus_err <= bus_sel && (rid == RID_NONE);
            if (wr_en) begin
                case (rid)
                    RID_OSC:   if (unlocked) osc_q <= bus_wdata;
                    RID_AUX:   if (unlocked) aux_q <= bus_wdata;
                    RID_LOCK:  lock_q <= bus_wdata[KEY_W-1:0];
                    RID_CTRL: begin
                        led_q     <= bus_wdata[0];
                        remap_ram <= bus_wdata[2];
                        rst_req   <= bus_wdata[3];
                    end
                    RID_SDRAM: sdram_q   <= bus_wdata;
                    RID_INIT:  init_q    <= bus_wdata;
                    RID_FLG_S: flags_q   <= flags_q | bus_wdata;
                    RID_FLG_C: flags_q   <= flags_q & ~bus_wdata;
                    RID_NVF_S: nvflags_q <= nvflags_q | bus_wdata;
                    RID_NVF_C: nvflags_q <= nvflags_q & ~bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (rid)
                RID_ID:      bus_rdata = ID_VALUE;
                RID_OSC:     bus_rdata = osc_q;
                RID_CTRL:    bus_rdata = {{(DATA_W-3){1'b0}}, remap_ram, 1'b0, led_q};
                RID_STAT:    bus_rdata = STAT_VALUE;
                RID_LOCK:    bus_rdata = {{(DATA_W-KEY_W-1){1'b0}}, unlocked, lock_q};
                RID_AUX:     bus_rdata = aux_q;
                RID_SDRAM:   bus_rdata = sdram_q;
                RID_INIT:    bus_rdata = init_q;
                RID_REF:     bus_rdata = ref_count;
                RID_FLG_S:   bus_rdata = flags_q;
                RID_NVF_S:   bus_rdata = nvflags_q;
                RID_IRQ_ST:  bus_rdata = {{(DATA_W-1){1'b0}}, sw_level & irq_en[0]};
                RID_IRQ_RAW: bus_rdata = {{(DATA_W-1){1'b0}}, sw_level};
                RID_IEN_S:   bus_rdata = irq_en;
                RID_SW_S:    bus_rdata = {{(DATA_W-1){1'b0}}, sw_level};
                RID_FIQ_ST:  bus_rdata = {{(DATA_W-1){1'b0}}, sw_level & fiq_en[0]};
                RID_FIQ_RAW: bus_rdata = {{(DATA_W-1){1'b0}}, sw_level};
                RID_FEN_S:   bus_rdata = fiq_en;
                RID_SPD:     bus_rdata = {{(DATA_W-8){1'b0}}, spd_data};
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cm_sysctl_chk.sv
module cm_sysctl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              rst_req,
    input logic              irq_out,
    input logic              fiq_out,
    input logic [31:0]       osc_q,
    input logic [31:0]       ref_count
);
    logic [ADDR_W-3:0] w;
    logic              wr, rd;
    logic [15:0]       key_shadow;

    always_comb begin
        w  = bus_addr[ADDR_W-1:2];
        wr = bus_sel & bus_wr;
        rd = bus_sel & ~bus_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) key_shadow <= '0;
        else if (wr && w == (ADDR_W-2)'(5)) key_shadow <= bus_wdata[15:0];
    end

    p_reset_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (wr && w == (ADDR_W-2)'(3) && bus_wdata[3]) |=> rst_req);

    p_no_stray_reset_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr && w == (ADDR_W-2)'(3) && bus_wdata[3]) |=> !rst_req);

    p_ctrl_bit3_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (rd && w == (ADDR_W-2)'(3)) |-> !bus_rdata[3]);

    p_osc_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && w == (ADDR_W-2)'(2) && key_shadow != 16'hA05F) |=> $stable(osc_q));

    p_ref_step_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ref_count == $past(ref_count) || ref_count == $past(ref_count) + 32'd1));

    p_err_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && (w == (ADDR_W-2)'(6) || w == (ADDR_W-2)'(11))) |=> bus_err);

    p_undecoded_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rd && w == (ADDR_W-2)'(6)) |-> bus_rdata == 32'd0);

    p_softclr_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && w == (ADDR_W-2)'(21) && bus_wdata[0]) |=> (!irq_out && !fiq_out));

    p_spd_high_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd && w >= (ADDR_W-2)'(96) && w <= (ADDR_W-2)'(127)) |-> bus_rdata == 32'd0);
endmodule

bind cm_sysctl cm_sysctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .rst_req   (rst_req),
    .irq_out   (irq_out),
    .fiq_out   (fiq_out),
    .osc_q     (osc_q),
    .ref_count (ref_count)
);

// File: tb/cm_sysctl_test.sv
`timescale 1ns/1ps
module cm_sysctl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, rst_req, remap_ram, irq_out, fiq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cm_sysctl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .rst_req(rst_req), .remap_ram(remap_ram),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 55;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 12'h000, 32'h411A3001, 4'd1},  // R1 id
        '{1'b0, 12'h010, 32'h00100000, 4'd1},  // R1 status
        '{1'b0, 12'h004, 32'h00000000, 4'd1},  // R1 proc
        '{1'b0, 12'h020, 32'h0001112E, 4'd2},  // R2 sdram with 128 MB code
        '{1'b0, 12'h024, 32'h00000112, 4'd2},  // R2 init
        '{1'b0, 12'h008, 32'h01000048, 4'd2},  // R2 osc
        '{1'b0, 12'h01C, 32'h0007FEFF, 4'd2},  // R2 aux
        '{1'b1, 12'h008, 32'h12345678, 4'd4},  // R4 locked write
        '{1'b0, 12'h008, 32'h01000048, 4'd4},
        '{1'b1, 12'h014, 32'h0001A05F, 4'd3},  // R3 unlock
        '{1'b0, 12'h014, 32'h0001A05F, 4'd3},
        '{1'b1, 12'h008, 32'hCAFEF00D, 4'd4},
        '{1'b0, 12'h008, 32'hCAFEF00D, 4'd4},
        '{1'b1, 12'h01C, 32'h00000055, 4'd4},
        '{1'b0, 12'h01C, 32'h00000055, 4'd4},
        '{1'b1, 12'h014, 32'hFFFF1234, 4'd3},  // R3 low 16 bits only
        '{1'b0, 12'h014, 32'h00001234, 4'd3},
        '{1'b1, 12'h01C, 32'h00000077, 4'd4},
        '{1'b0, 12'h01C, 32'h00000055, 4'd4},
        '{1'b1, 12'h00C, 32'h00000007, 4'd5},  // R5 bits kept
        '{1'b0, 12'h00C, 32'h00000005, 4'd5},
        '{1'b1, 12'h00C, 32'h00000002, 4'd5},
        '{1'b0, 12'h00C, 32'h00000000, 4'd5},
        '{1'b1, 12'h030, 32'h000000F0, 4'd6},  // R6 flags set
        '{1'b1, 12'h030, 32'h0000000F, 4'd6},
        '{1'b0, 12'h030, 32'h000000FF, 4'd6},
        '{1'b1, 12'h034, 32'h0000003C, 4'd6},
        '{1'b0, 12'h030, 32'h000000C3, 4'd6},
        '{1'b1, 12'h038, 32'h00000081, 4'd6},
        '{1'b1, 12'h03C, 32'h00000001, 4'd6},
        '{1'b0, 12'h038, 32'h00000080, 4'd6},
        '{1'b0, 12'h030, 32'h000000C3, 4'd6},
        '{1'b1, 12'h048, 32'h00000003, 4'd9},  // R9 irq enables
        '{1'b1, 12'h04C, 32'h00000002, 4'd9},
        '{1'b0, 12'h048, 32'h00000001, 4'd9},
        '{1'b1, 12'h050, 32'h00000001, 4'd8},  // R8 soft set
        '{1'b0, 12'h050, 32'h00000001, 4'd8},
        '{1'b0, 12'h044, 32'h00000001, 4'd8},
        '{1'b0, 12'h064, 32'h00000001, 4'd8},
        '{1'b0, 12'h040, 32'h00000001, 4'd9},
        '{1'b0, 12'h060, 32'h00000000, 4'd9},
        '{1'b1, 12'h068, 32'h00000001, 4'd9},
        '{1'b0, 12'h060, 32'h00000001, 4'd9},
        '{1'b1, 12'h054, 32'h00000001, 4'd8},  // R8 soft clear
        '{1'b0, 12'h044, 32'h00000000, 4'd8},
        '{1'b0, 12'h040, 32'h00000000, 4'd9},
        '{1'b0, 12'h100, 32'h00000080, 4'd10}, // R10 table
        '{1'b0, 12'h10C, 32'h0000000B, 4'd10},
        '{1'b0, 12'h17C, 32'h00000020, 4'd10},
        '{1'b0, 12'h180, 32'h00000000, 4'd10},
        '{1'b0, 12'h1FC, 32'h00000000, 4'd10},
        '{1'b1, 12'h080, 32'hFFFFFFFF, 4'd11}, // R11 voltage word
        '{1'b0, 12'h080, 32'h00000000, 4'd11},
        '{1'b1, 12'h020, 32'h00000ABC, 4'd2},
        '{1'b0, 12'h020, 32'h00000ABC, 4'd2}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, c1, c2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // reset state
        check("R5 rst_req after reset", {31'b0, rst_req}, 32'd0);
        check("R5 remap_ram after reset", {31'b0, remap_ram}, 32'd0);
        check("R9 irq/fiq after reset", {30'b0, irq_out, fiq_out}, 32'd0);
        check("R11 bus_err after reset", {31'b0, bus_err}, 32'd0);
        do_read(12'h028, d);
        check("R7 counter zero after reset", d, 32'd0);

        // R7 rate windows
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h028;
        #1 c1 = bus_rdata;
        repeat (250) @(negedge clk);
        #1 c2 = bus_rdata;
        check("R7 ticks per 250 cycles", c2 - c1, 32'd24);
        repeat (125) @(negedge clk);
        #1 c1 = bus_rdata;
        check("R7 ticks per 125 cycles", c1 - c2, 32'd12);
        @(negedge clk);
        bus_sel = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                do_write(VEC[i].addr, VEC[i].data);
            end else begin
                do_read(VEC[i].addr, d);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), d, VEC[i].data);
            end
        end

        // R5 reset request pulse and remap select
        do_write(12'h00C, 32'h00000008);
        check("R5 rst_req pulse high", {31'b0, rst_req}, 32'd1);
        @(negedge clk); #1;
        check("R5 rst_req pulse ends", {31'b0, rst_req}, 32'd0);
        do_write(12'h00C, 32'h00000004);
        check("R5 remap_ram set", {31'b0, remap_ram}, 32'd1);
        do_write(12'h00C, 32'h00000000);
        check("R5 remap_ram clear", {31'b0, remap_ram}, 32'd0);

        // R9 interrupt lines (irq enable 1, fiq enable 1 from table)
        do_write(12'h050, 32'h00000001);
        check("R9 irq_out and fiq_out on", {30'b0, irq_out, fiq_out}, 32'd3);
        do_write(12'h06C, 32'h00000001);
        check("R9 fiq masked", {30'b0, irq_out, fiq_out}, 32'd2);
        do_write(12'h054, 32'h00000001);
        check("R8 level cleared lines off", {30'b0, irq_out, fiq_out}, 32'd0);

        // R11 undecoded access
        do_write(12'h018, 32'h00000005);
        check("R11 bus_err after write", {31'b0, bus_err}, 32'd1);
        @(negedge clk); #1;
        check("R11 bus_err one cycle", {31'b0, bus_err}, 32'd0);
        do_read(12'h018, d);
        check("R11 undecoded reads zero", d, 32'd0);
        check("R11 bus_err after read", {31'b0, bus_err}, 32'd1);
        do_write(12'h02C, 32'hFFFFFFFF);
        do_read(12'h030, d);
        check("R11 undecoded write ignored", d, 32'h000000C3);
        do_write(12'h088, 32'h00000001);
        check("R11 voltage word no error", {31'b0, bus_err}, 32'd0);
        do_write(12'h000, 32'hFFFFFFFF);
        do_read(12'h000, d);
        check("R1 id ignores writes", d, 32'h411A3001);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule